// File: doc/BRIEF.md
# Static-Drive LCD Segment Driver

This block drives a twisted-nematic LCD panel at 1:1 duty. A host sends display bits over three wires: a data bit, a data clock and a load strobe. The bits enter a 40-stage shift register, and a load strobe copies them into a display latch. Each of the 40 segment outputs and the two backplane outputs carries an AC square wave taken from a slow LCD clock. A lit segment runs in antiphase with the backplane. A dark segment runs in phase with it, so the glass never sees a DC bias. The most significant stage of the shift register feeds a cascade output, so two or three drivers can be chained into a longer display.

A blink enable and an external blink clock gate the display. While blinking is on, the display goes dark during the low half of the blink clock. Four active-low enables act on the outputs: one for segments 1–16, one for segments 17–40, and one for each backplane. A disabled output is held low. Every slow input (data, data clock, load, LCD clock and blink clock) passes through a two-flop synchronizer into the system clock domain, and edges are detected there.

Top module: `static_lcd_drv`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_din` into stage 0 and moves every stage up by one. The segment-40 bit is sent first. After 40 edges, the last bit sent sits in latch bit 0 and drives `seg[0]` (segment 1), and bit k drives `seg[k]`.
- R2: A rising edge of `ser_load` copies all 40 stages into the display latch. The segments follow only the latch, so shifting without a load leaves them unchanged.
- R3: `cascade_out` carries the bit that entered the shift register 40 data-clock edges before the next edge. This is the top stage (bit 39).
- R4: After reset, the shift register and the latch are all zero. Every enabled segment is then in phase with the backplanes (dark), and `cascade_out` is 0.
- R5: Each backplane output is the inverse of `lcd_clk` while its own enable (`bp_a_en_n` or `bp_b_en_n`) is low, and is held at 0 while that enable is high. The two backplanes are controlled independently.
- R6: An enabled segment whose latch bit is 1 outputs `lcd_clk` (antiphase with the backplane). An enabled segment whose latch bit is 0 outputs the inverse of `lcd_clk` (in phase with the backplane).
- R7: With `grp_lo_en_n` high, `seg[15:0]` are held at 0. With `grp_hi_en_n` high, `seg[39:16]` are held at 0. Each enable leaves the other group unaffected.
- R8: With `blink_en_n` low and `blink_clk` low, every enabled segment outputs the inverse of `lcd_clk` (dark). With `blink_clk` high, the latch is shown. With `blink_en_n` high, `blink_clk` has no effect.
- R9: When a load edge and a data-clock edge are detected in the same system cycle, the latch takes the shift register contents from before that shift, and the shift still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_din | input | 1 | Serial display data |
| ser_clk | input | 1 | Serial data clock, rising-edge active |
| ser_load | input | 1 | Load strobe, rising-edge active |
| lcd_clk | input | 1 | Low-frequency LCD drive clock |
| blink_clk | input | 1 | Blink gating clock |
| blink_en_n | input | 1 | Blink enable, active low |
| grp_lo_en_n | input | 1 | Enable for segments 1–16, active low |
| grp_hi_en_n | input | 1 | Enable for segments 17–40, active low |
| bp_a_en_n | input | 1 | Enable for backplane A, active low |
| bp_b_en_n | input | 1 | Enable for backplane B, active low |
| seg | output | 40 | Segment drive waveforms, bit 0 = segment 1 |
| bp_a | output | 1 | Backplane A drive |
| bp_b | output | 1 | Backplane B drive |
| cascade_out | output | 1 | Top shift stage, feeds the next driver's data input |

## Verification
The shift path and the load path can act in the same system cycle. The load must then capture the pre-shift contents while the shift still advances. The bench provokes this by raising the data clock and the load strobe in one assignment, with a shift register that holds a pattern not yet loaded. It judges the result at the segment pins: with the LCD clock high, the segments show the latch directly. The captured word must be the unshifted pattern, and a later plain load must show the pattern shifted by one.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int unsigned SEG_N    = 40;
  localparam int unsigned GRP_LO_N = 16;
  localparam int unsigned SYNC_W   = 5;
  // bit positions inside the synchronized input bus
  localparam int unsigned IX_DIN   = 0;
  localparam int unsigned IX_SCLK  = 1;
  localparam int unsigned IX_LOAD  = 2;
  localparam int unsigned IX_LCK   = 3;
  localparam int unsigned IX_BCLK  = 4;
endpackage

// File: rtl/lcd_sync_edge.sv
module lcd_sync_edge #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/lcd_shift_latch.sv
module lcd_shift_latch #(
  parameter int unsigned N = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  input  logic         shift_p,
  input  logic         load_p,
  output logic [N-1:0] shreg,
  output logic [N-1:0] latch
);
  logic [N-1:0] sh_nx, lt_nx;

  always_comb begin
    sh_nx = shreg;
    lt_nx = latch;
    if (shift_p) sh_nx = {shreg[N-2:0], din};
    if (load_p)  lt_nx = shreg;  // pre-shift value on coincidence
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      latch <= '0;
    end else begin
      if (shift_p) shreg <= sh_nx;
      if (load_p)  latch <= lt_nx;
    end
  end
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive #(
  parameter int unsigned N    = 40,
  parameter int unsigned LO_N = 16
) (
  input  logic [N-1:0] latch,
  input  logic         lck,
  input  logic         bclk,
  input  logic         blink_en_n,
  input  logic         grp_lo_en_n,
  input  logic         grp_hi_en_n,
  input  logic         bp_a_en_n,
  input  logic         bp_b_en_n,
  output logic [N-1:0] seg,
  output logic         bp_a,
  output logic         bp_b
);
  logic show_ok;
  assign show_ok = blink_en_n | bclk;

  for (genvar i = 0; i < N; i++) begin : g_seg
    logic en, lit;
    if (i < LO_N) begin : g_lo
      assign en = ~grp_lo_en_n;
    end else begin : g_hi
      assign en = ~grp_hi_en_n;
    end
    assign lit    = latch[i] & show_ok;
    assign seg[i] = en & (lit ? lck : ~lck);
  end

  assign bp_a = ~bp_a_en_n & ~lck;
  assign bp_b = ~bp_b_en_n & ~lck;
endmodule

// File: rtl/static_lcd_drv.sv
module static_lcd_drv
  import lcd_drv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_din,
  input  logic             ser_clk,
  input  logic             ser_load,
  input  logic             lcd_clk,
  input  logic             blink_clk,
  input  logic             blink_en_n,
  input  logic             grp_lo_en_n,
  input  logic             grp_hi_en_n,
  input  logic             bp_a_en_n,
  input  logic             bp_b_en_n,
  output logic [SEG_N-1:0] seg,
  output logic             bp_a,
  output logic             bp_b,
  output logic             cascade_out
);
  logic [1:0]        rst_q;
  logic              rst_sync_n;
  logic [SYNC_W-1:0] in_raw, in_lvl, in_rise;
  logic              shift_p, load_p, lck, bclk_s;
  logic [SEG_N-1:0]  shreg, latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  always_comb begin
    in_raw          = '0;
    in_raw[IX_DIN]  = ser_din;
    in_raw[IX_SCLK] = ser_clk;
    in_raw[IX_LOAD] = ser_load;
    in_raw[IX_LCK]  = lcd_clk;
    in_raw[IX_BCLK] = blink_clk;
  end

  lcd_sync_edge #(.W(SYNC_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    (in_raw),
    .lvl  (in_lvl),
    .rise (in_rise)
  );

  assign shift_p = in_rise[IX_SCLK];
  assign load_p  = in_rise[IX_LOAD];
  assign lck     = in_lvl[IX_LCK];
  assign bclk_s  = in_lvl[IX_BCLK];

  lcd_shift_latch #(.N(SEG_N)) u_sr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .din    (in_lvl[IX_DIN]),
    .shift_p(shift_p),
    .load_p (load_p),
    .shreg  (shreg),
    .latch  (latch)
  );

  assign cascade_out = shreg[SEG_N-1];

  lcd_seg_drive #(.N(SEG_N), .LO_N(GRP_LO_N)) u_drv (
    .latch      (latch),
    .lck        (lck),
    .bclk       (bclk_s),
    .blink_en_n (blink_en_n),
    .grp_lo_en_n(grp_lo_en_n),
    .grp_hi_en_n(grp_hi_en_n),
    .bp_a_en_n  (bp_a_en_n),
    .bp_b_en_n  (bp_b_en_n),
    .seg        (seg),
    .bp_a       (bp_a),
    .bp_b       (bp_b)
  );
endmodule

// File: rtl/static_lcd_drv_chk.sv
module static_lcd_drv_chk #(
  parameter int unsigned N    = 40,
  parameter int unsigned LO_N = 16
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         shift_p,
  input logic         load_p,
  input logic         bclk_s,
  input logic [N-1:0] shreg,
  input logic [N-1:0] latch,
  input logic [N-1:0] seg,
  input logic         bp_a,
  input logic         bp_b,
  input logic         blink_en_n,
  input logic         grp_lo_en_n,
  input logic         grp_hi_en_n,
  input logic         bp_a_en_n,
  input logic         bp_b_en_n
);
  p_shift_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    shift_p |=> shreg[N-1:1] == $past(shreg[N-2:0]));

  // R2 and R9: a load captures the register value seen before any same-cycle shift
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_p |=> latch == $past(shreg));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !load_p |=> $stable(latch));

  p_bp_pair_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bp_a_en_n && !bp_b_en_n) |-> bp_a == bp_b);

  p_polarity_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (blink_en_n && !grp_lo_en_n && !bp_a_en_n) |-> ((seg[0] != bp_a) == latch[0]));

  p_grp_off_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    grp_hi_en_n |-> seg[N-1:LO_N] == '0);

  p_blank_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!blink_en_n && !bclk_s && !grp_lo_en_n && !bp_a_en_n) |-> seg[LO_N-1:0] == {LO_N{bp_a}});
endmodule

bind static_lcd_drv static_lcd_drv_chk #(.N(lcd_drv_pkg::SEG_N), .LO_N(lcd_drv_pkg::GRP_LO_N)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .shift_p    (shift_p),
  .load_p     (load_p),
  .bclk_s     (bclk_s),
  .shreg      (shreg),
  .latch      (latch),
  .seg        (seg),
  .bp_a       (bp_a),
  .bp_b       (bp_b),
  .blink_en_n (blink_en_n),
  .grp_lo_en_n(grp_lo_en_n),
  .grp_hi_en_n(grp_hi_en_n),
  .bp_a_en_n  (bp_a_en_n),
  .bp_b_en_n  (bp_b_en_n)
);

// File: tb/tb_static_lcd_drv.sv
module tb_static_lcd_drv;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_din, ser_clk, ser_load, lcd_clk, blink_clk;
  logic        blink_en_n, grp_lo_en_n, grp_hi_en_n, bp_a_en_n, bp_b_en_n;
  logic [39:0] seg;
  logic        bp_a, bp_b, cascade_out;
  int          n_vec = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  static_lcd_drv dut (
    .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_clk(ser_clk),
    .ser_load(ser_load), .lcd_clk(lcd_clk), .blink_clk(blink_clk),
    .blink_en_n(blink_en_n), .grp_lo_en_n(grp_lo_en_n), .grp_hi_en_n(grp_hi_en_n),
    .bp_a_en_n(bp_a_en_n), .bp_b_en_n(bp_b_en_n), .seg(seg), .bp_a(bp_a),
    .bp_b(bp_b), .cascade_out(cascade_out)
  );

  typedef struct packed {
    logic [39:0] d;
    logic ben_n, bclk, lo_n, hi_n, a_n, b_n;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{40'h00_0000_0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{40'h80_0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{40'hA5_C3F0_0F5A, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{40'h5A_3C0F_F0A5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{40'hFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{40'h12_3456_789A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{40'hFE_DCBA_9876, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [39:0] exp_seg(vec_t v, logic lck);
    logic [39:0] r;
    for (int i = 0; i < 40; i++) begin
      logic en, lit;
      en   = (i < 16) ? ~v.lo_n : ~v.hi_n;
      lit  = v.d[i] & (v.ben_n | v.bclk);
      r[i] = en & (lit ? lck : ~lck);
    end
    return r;
  endfunction

  task automatic settle();
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [39:0] act, logic [39:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    ser_din = b;
    settle();
    ser_clk = 1'b1;
    settle();
    ser_clk = 1'b0;
    settle();
  endtask

  task automatic send_word(logic [39:0] w);
    for (int i = 39; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_load();
    ser_load = 1'b1;
    settle();
    ser_load = 1'b0;
    settle();
  endtask

  task automatic apply(vec_t v);
    blink_en_n  = v.ben_n;
    blink_clk   = v.bclk;
    grp_lo_en_n = v.lo_n;
    grp_hi_en_n = v.hi_n;
    bp_a_en_n   = v.a_n;
    bp_b_en_n   = v.b_n;
  endtask

  // check segments and both backplanes over a full LCD clock period
  task automatic check_disp(string req, vec_t v);
    for (int p = 0; p < 2; p++) begin
      lcd_clk = p[0];
      settle();
      check(req, seg, exp_seg(v, p[0]));
      check("R5 bp_a", {39'd0, bp_a}, {39'd0, ~v.a_n & ~p[0]});
      check("R5 bp_b", {39'd0, bp_b}, {39'd0, ~v.b_n & ~p[0]});
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    vec_t plain;
    plain = '{40'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    rst_n = 1'b0;
    ser_din = 0; ser_clk = 0; ser_load = 0; lcd_clk = 0;
    apply(plain);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();

    // R4: reset state, every segment dark
    check_disp("R4 reset segs dark", plain);
    check("R4 cascade after reset", {39'd0, cascade_out}, 40'd0);

    // table walk: R1 ordering, R6 polarity, R7 groups, R8 blink, R5 backplanes
    foreach (VEC[k]) begin
      apply(plain);
      send_word(VEC[k].d);
      check("R3 cascade holds first bit", {39'd0, cascade_out}, {39'd0, VEC[k].d[39]});
      pulse_load();
      apply(VEC[k]);
      check_disp("R1 R6 R7 R8 table", VEC[k]);
    end

    // R2: shifting without a load leaves the display unchanged
    apply(plain);
    plain.d = VEC[6].d;
    send_word(40'h0F_0F0F_0F0F);
    check_disp("R2 no load, display held", plain);
    pulse_load();
    plain.d = 40'h0F_0F0F_0F0F;
    check_disp("R2 load shows new word", plain);

    // R3: cascade output walks out the earlier word one bit per edge
    send_word(40'hC6_0000_0000);
    check("R3 cascade bit39", {39'd0, cascade_out}, 40'd1);
    send_bit(1'b0);
    check("R3 cascade bit38", {39'd0, cascade_out}, 40'd1);
    send_bit(1'b0);
    check("R3 cascade bit37", {39'd0, cascade_out}, 40'd0);
    send_bit(1'b0);
    check("R3 cascade bit36", {39'd0, cascade_out}, 40'd0);

    // R9: coincident shift and load edges
    send_word(40'h3C_5A00_FF81);
    ser_din  = 1'b1;
    settle();
    ser_clk  = 1'b1;
    ser_load = 1'b1;
    settle();
    ser_clk  = 1'b0;
    ser_load = 1'b0;
    settle();
    plain.d = 40'h3C_5A00_FF81;
    check_disp("R9 coincident load takes pre-shift word", plain);
    pulse_load();
    plain.d = {40'h3C_5A00_FF81 << 1} | 40'd1;
    check_disp("R9 shift still happened", plain);

    // R8: blink clock ignored while blink disabled
    plain.bclk = 1'b0;
    apply(plain);
    check_disp("R8 blink clock ignored", plain);

    // R4: mid-run reset clears latch and shift register
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();
    plain.d = '0;
    check_disp("R4 reset clears latch", plain);
    check("R4 cascade cleared", {39'd0, cascade_out}, 40'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule